// File: doc/BRIEF.md
# Rounding Saturating Narrowing Vector Shifter

This block is a SIMD datapath stage. It takes a source vector split into unsigned 32-bit lanes, a destination vector of the same width, and a shift amount. Each 32-bit lane is shifted right with round-half-up rounding. The result is clamped to an unsigned 16-bit value and placed in the upper 16-bit half of the matching 32-bit slot of the output. The lower 16-bit half of every slot is copied from the destination vector without change.

The vector width is a parameter. It can be any power of two from 128 to 2048 bits, and every lane behaves the same at every width. Operands enter through a valid/ready handshake and leave through a single output register. If the shift amount is outside the legal range, the block sets an error flag and returns the destination vector untouched.

Top module: `rsn_narrow_shifter`

## Requirements
- R1: For a shift amount s in 1..16, each lane result equals floor(src / 2^s), plus one when bit s-1 of src is 1. The addition is at least 33 bits wide, so 0xFFFFFFFF does not wrap.
- R2: A rounded lane result above 0xFFFF is output as 0xFFFF.
- R3: The result for source lane i (bits 32i+31:32i) appears on output bits 32i+31:32i+16.
- R4: Output bits 32i+15:32i equal the destination input bits 32i+15:32i for every lane, with any shift amount.
- R5: Bit i of out_sat is 1 exactly when lane i was clamped under R2. All bits are 0 when out_err is 1.
- R6: A shift amount of 0 or greater than 16 sets out_err to 1 and makes out_vec equal the destination input, with out_sat all 0. A legal shift amount gives out_err 0.
- R7: An operand set is accepted on a rising clock edge where in_valid and in_ready are both 1. Its result is shown with out_valid = 1 from the next edge on.
- R8: While out_valid is 1 and out_ready is 0, in_ready is 0, and out_vec, out_sat and out_err hold their values. Inputs offered during that time are not taken.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can take an operand set |
| src_vec | input | VEC_BITS | Source vector of 32-bit lanes |
| dst_vec | input | VEC_BITS | Destination vector; supplies the lower halves |
| shamt | input | SH_W | Right shift amount |
| out_valid | output | 1 | Registered result available |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | VEC_BITS | Narrowed, merged result vector |
| out_sat | output | VEC_BITS/32 | Per-lane clamp flags |
| out_err | output | 1 | Shift amount was out of range |

## Verification
The assertions check the handshake rules on every cycle:
- the output holds and in_ready is low under backpressure;
- out_valid rises only after an accepted transfer;
- the error result passes the destination vector through with no flags set;
- every raised clamp flag sits on an all-ones upper half.

The arithmetic itself can only be shown by the bench's scenarios:
- rounding just below and just above the half-LSB point;
- the exact point where a result starts to saturate;
- the extreme shifts of 1 and 16 and the all-ones source;
- random lanes compared with a model built on plain shift and increment.

// File: rtl/rsn_pkg.sv
package rsn_pkg;
   localparam int unsigned WIDE_LANE   = 32;
   localparam int unsigned NARROW_LANE = 16;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/rsn_shamt_check.sv
module rsn_shamt_check #(
   parameter int unsigned SH_W   = 5,
   parameter int unsigned SH_MIN = 1,
   parameter int unsigned SH_MAX = 16
) (
   input  logic [SH_W-1:0] shamt,
   output logic            legal
);
   localparam logic [SH_W-1:0] LO = SH_W'(SH_MIN);
   localparam logic [SH_W-1:0] HI = SH_W'(SH_MAX);

   if (SH_MAX >= (1 << SH_W)) begin : g_bad_range
      $error("SH_MAX does not fit in SH_W bits");
   end

   always_comb legal = (shamt >= LO) && (shamt <= HI);
endmodule

// File: rtl/rsn_lane.sv
module rsn_lane #(
   parameter int unsigned WIDE_W   = 32,
   parameter int unsigned NARROW_W = 16,
   parameter int unsigned SH_W     = 5
) (
   input  logic [WIDE_W-1:0]   src,
   input  logic [SH_W-1:0]     sh,
   output logic [NARROW_W-1:0] res,
   output logic                sat
);
   localparam int unsigned SUM_W = WIDE_W + 1;

   logic [SUM_W-1:0] half_lsb;
   logic [SUM_W-1:0] biased;
   logic [SUM_W-1:0] shifted;

   always_comb begin
      half_lsb = {{(SUM_W-1){1'b0}}, 1'b1} << (sh - SH_W'(1));
      biased   = {1'b0, src} + half_lsb;
      shifted  = biased >> sh;
      sat      = |shifted[SUM_W-1:NARROW_W];
      res      = sat ? {NARROW_W{1'b1}} : shifted[NARROW_W-1:0];
   end
endmodule

// File: rtl/rsn_out_reg.sv
module rsn_out_reg #(
   parameter int unsigned VEC_BITS = 128,
   parameter int unsigned LANES    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [VEC_BITS-1:0] nxt_vec,
   input  logic [LANES-1:0]    nxt_sat,
   input  logic                nxt_err,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [VEC_BITS-1:0] out_vec,
   output logic [LANES-1:0]    out_sat,
   output logic                out_err
);
   logic take;

   always_comb begin
      in_ready = !out_valid || out_ready;
      take     = in_valid && in_ready;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_vec   <= '0;
         out_sat   <= '0;
         out_err   <= 1'b0;
      end else if (take) begin
         out_valid <= 1'b1;
         out_vec   <= nxt_vec;
         out_sat   <= nxt_sat;
         out_err   <= nxt_err;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)
                                     && $stable(out_sat) && $stable(out_err)));

   a_r7_valid_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

// File: rtl/rsn_narrow_shifter.sv
module rsn_narrow_shifter #(
   parameter int unsigned VEC_BITS = 128,
   parameter int unsigned SH_W     = 5,
   parameter int unsigned SH_MIN   = 1,
   parameter int unsigned SH_MAX   = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 in_valid,
   output logic                                 in_ready,
   input  logic [VEC_BITS-1:0]                  src_vec,
   input  logic [VEC_BITS-1:0]                  dst_vec,
   input  logic [SH_W-1:0]                      shamt,
   output logic                                 out_valid,
   input  logic                                 out_ready,
   output logic [VEC_BITS-1:0]                  out_vec,
   output logic [VEC_BITS/rsn_pkg::WIDE_LANE-1:0] out_sat,
   output logic                                 out_err
);
   import rsn_pkg::*;

   localparam int unsigned WW    = WIDE_LANE;
   localparam int unsigned NW    = NARROW_LANE;
   localparam int unsigned LANES = VEC_BITS / WW;

   if (VEC_BITS < 128 || VEC_BITS > 2048 || !is_pow2(VEC_BITS)) begin : g_bad_vec
      $error("VEC_BITS must be a power of two from 128 to 2048");
   end
   if (SH_MIN < 1 || SH_MAX > NW || SH_MIN > SH_MAX) begin : g_bad_sh
      $error("shift range must lie within 1..16");
   end

   logic                legal;
   logic [VEC_BITS-1:0] nxt_vec;
   logic [LANES-1:0]    nxt_sat;

   rsn_shamt_check #(.SH_W(SH_W), .SH_MIN(SH_MIN), .SH_MAX(SH_MAX)) i_chk (
      .shamt (shamt),
      .legal (legal)
   );

   for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
      logic [NW-1:0] lane_res;
      logic          lane_sat;

      rsn_lane #(.WIDE_W(WW), .NARROW_W(NW), .SH_W(SH_W)) i_lane (
         .src (src_vec[gi*WW +: WW]),
         .sh  (shamt),
         .res (lane_res),
         .sat (lane_sat)
      );

      always_comb begin
         nxt_vec[gi*WW +: NW]      = dst_vec[gi*WW +: NW];
         nxt_vec[gi*WW + NW +: NW] = legal ? lane_res : dst_vec[gi*WW + NW +: NW];
         nxt_sat[gi]               = legal && lane_sat;
      end

      a_r5_flag_means_clamp: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_sat[gi]) |-> (out_vec[gi*WW + NW +: NW] == {NW{1'b1}}));
   end

   rsn_out_reg #(.VEC_BITS(VEC_BITS), .LANES(LANES)) i_oreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .nxt_vec   (nxt_vec),
      .nxt_sat   (nxt_sat),
      .nxt_err   (!legal),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_vec   (out_vec),
      .out_sat   (out_sat),
      .out_err   (out_err)
   );

   a_r6_err_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_sat == '0));

   a_r6_err_passes_dst: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(out_valid) && out_err) |-> (out_vec == $past(dst_vec)));
endmodule

// File: tb/test_rsn_narrow_shifter.sv
`timescale 1ns/1ps
module test_rsn_narrow_shifter;
   localparam int VB = 256;
   localparam int LN = VB / 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [VB-1:0] src_vec = '0;
   logic [VB-1:0] dst_vec = '0;
   logic [4:0]    shamt = 5'd1;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [VB-1:0] out_vec;
   logic [LN-1:0] out_sat;
   logic          out_err;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   rsn_narrow_shifter #(.VEC_BITS(VB)) i_rsn_narrow_shifter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .src_vec(src_vec), .dst_vec(dst_vec), .shamt(shamt),
      .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
      .out_sat(out_sat), .out_err(out_err)
   );

   // model: plain shift, then add the last bit shifted out
   function automatic logic [32:0] model_round(input logic [31:0] s, input int sh);
      logic [32:0] q;
      q = {1'b0, s >> sh};
      if (s[sh-1]) q = q + 33'd1;
      return q;
   endfunction

   function automatic logic [VB-1:0] model_vec(input logic [VB-1:0] s, input logic [VB-1:0] d,
                                              input int sh);
      logic [VB-1:0] r;
      r = d;
      if (sh >= 1 && sh <= 16)
         for (int i = 0; i < LN; i++) begin
            logic [32:0] q;
            q = model_round(s[i*32 +: 32], sh);
            r[i*32+16 +: 16] = (q > 33'h0FFFF) ? 16'hFFFF : q[15:0];
         end
      return r;
   endfunction

   function automatic logic [LN-1:0] model_sat(input logic [VB-1:0] s, input int sh);
      logic [LN-1:0] f;
      f = '0;
      if (sh >= 1 && sh <= 16)
         for (int i = 0; i < LN; i++)
            f[i] = model_round(s[i*32 +: 32], sh) > 33'h0FFFF;
      return f;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [VB-1:0] act,
                      input logic [VB-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [VB-1:0] s, input logic [VB-1:0] d, input int sh,
                         input string tag);
      logic [VB-1:0] ev;
      logic [LN-1:0] es;
      bit            ee;
      ev = model_vec(s, d, sh);
      es = model_sat(s, sh);
      ee = !(sh >= 1 && sh <= 16);
      @(negedge clk);
      src_vec = s; dst_vec = d; shamt = 5'(sh); in_valid = 1'b1; out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, {tag, " R7 out_valid"}, VB'(out_valid), VB'(1));
      chk(out_vec == ev, {tag, " R1 R3 R4 out_vec"}, out_vec, ev);
      chk(out_sat == es, {tag, " R5 out_sat"}, VB'(out_sat), VB'(es));
      chk(out_err == ee, {tag, " R6 out_err"}, VB'(out_err), VB'(ee));
   endtask

   function automatic logic [VB-1:0] fill(input logic [31:0] w);
      logic [VB-1:0] r;
      for (int i = 0; i < LN; i++) r[i*32 +: 32] = w;
      return r;
   endfunction

   function automatic logic [VB-1:0] rnd_vec();
      logic [VB-1:0] r;
      for (int i = 0; i < LN; i++) r[i*32 +: 32] = $urandom >> ($urandom % 32);
      return r;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [VB-1:0] dpat;
      logic [VB-1:0] held;
      void'($urandom(20240611));
      dpat = {LN{32'hA5A5_1234}};
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 reset out_valid", VB'(out_valid), VB'(0));
      chk(in_ready == 1'b1, "R9 reset in_ready", VB'(in_ready), VB'(1));
      rst_n = 1'b1;

      // R1 corner cases
      run_op('0, dpat, 1, "zero s1");
      run_op('0, dpat, 16, "zero s16");
      run_op(fill(32'd5), dpat, 1, "R1 5>>1 up");
      run_op(fill(32'd4), dpat, 1, "R1 4>>1 exact");
      run_op(fill(32'h0001_7FFF), dpat, 16, "R1 boundary below");
      run_op(fill(32'h0001_8000), dpat, 16, "R1 boundary on");
      // R2 saturation edge and all ones (no 32-bit wrap)
      run_op(fill(32'hFFFF_7FFF), dpat, 16, "R2 just fits");
      run_op(fill(32'hFFFF_8000), dpat, 16, "R2 just clamps");
      run_op(fill(32'hFFFF_FFFF), dpat, 16, "R2 all ones s16");
      run_op(fill(32'hFFFF_FFFF), dpat, 1, "R2 all ones s1");
      run_op(fill(32'h0001_FFFE), dpat, 1, "R2 s1 fits");
      run_op(fill(32'h0001_FFFF), dpat, 1, "R2 s1 clamps");
      // R3 distinct lanes land in their own slots
      begin
         logic [VB-1:0] s;
         for (int i = 0; i < LN; i++) s[i*32 +: 32] = 32'(i + 1) << 8;
         run_op(s, dpat, 8, "R3 lane order");
      end
      // R4 even halves from dst with random dst
      run_op(rnd_vec(), {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                         $urandom, $urandom}, 4, "R4 even pass");
      // R6 illegal shifts
      run_op(rnd_vec(), dpat, 0, "R6 shift 0");
      run_op(rnd_vec(), dpat, 17, "R6 shift 17");
      run_op(fill(32'hFFFF_FFFF), dpat, 31, "R6 shift 31");

      // R8 backpressure
      @(negedge clk);
      src_vec = fill(32'h0000_0300); dst_vec = dpat; shamt = 5'd8;
      in_valid = 1'b1; out_ready = 1'b0;
      @(posedge clk);
      @(negedge clk);
      held = out_vec;
      chk(in_ready == 1'b0, "R8 in_ready low", VB'(in_ready), VB'(0));
      chk(held == model_vec(fill(32'h0000_0300), dpat, 8), "R8 first result",
          held, model_vec(fill(32'h0000_0300), dpat, 8));
      src_vec = fill(32'h0700_0000); shamt = 5'd2;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b1, "R8 valid held", VB'(out_valid), VB'(1));
      chk(out_vec == held, "R8 data held", out_vec, held);
      in_valid = 1'b0; out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 offered input not taken", VB'(out_valid), VB'(0));

      // random mix
      for (int n = 0; n < 300; n++) begin
         int sh;
         sh = ($urandom % 10 == 0) ? int'($urandom % 32) : int'($urandom % 16) + 1;
         run_op(rnd_vec(), {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                            $urandom, $urandom}, sh, "R1 R2 random");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule